// File: doc/BRIEF.md
# Range Classification Result Cache

This block sits between a packet pipeline and a slow classification engine. The header fields that drive classification are treated as a single numeric key. Each cache line stores an inclusive interval of that key space and one decision that is valid for every key inside the interval. Many neighbouring keys that share a decision can therefore be served by one line.

A lookup whose key falls inside a valid line is answered on the next cycle with that line's decision. When no line covers the key, the cache holds the key toward the backing classifier and accepts no further lookups. It waits until the classifier sends back an interval and a decision. The decision answers the stalled lookup, and the interval is installed for later packets of the same flow. The cache never prefetches neighbouring intervals. A flush input drops every line at once.

Top module: `range_cache`

## Requirements
- R1: After reset no line is valid, `lkp_ready` is 1, and `rsp_valid` and `miss_req` are 0. The first lookup after reset therefore misses.
- R2: An accepted lookup (`lkp_valid` and `lkp_ready` both 1 at a clock edge) whose key k satisfies lo <= k <= hi for a valid line gives `rsp_valid`=1, `rsp_hit`=1 and that line's result in the cycle after the edge. Both bounds are inclusive.
- R3: An accepted lookup that matches no valid line gives `rsp_valid`=0 in the cycle after the edge. In that same cycle `miss_req`=1, `miss_key` holds the key, and `lkp_ready`=0.
- R4: A fill (`fill_valid`=1 while `miss_req`=1) gives `rsp_valid`=1, `rsp_hit`=0 and `rsp_result`=`fill_result` in the following cycle. In that cycle `miss_req` drops to 0 and `lkp_ready` returns to 1. The interval [`fill_lo`, `fill_hi`] is installed, and later lookups inside it hit. The interval need not contain the missed key.
- R5: `fill_valid` while `miss_req`=0 has no effect: no response is produced and no line is installed.
- R6: When a key lies in several valid lines, the line with the lowest index supplies the result, whatever order the lines were installed in.
- R7: A fill is placed in the lowest-index invalid line when one exists. No valid line is evicted while an invalid line remains.
- R8: When all lines are valid, a fill replaces the line selected by a rotating pointer. The pointer is 0 after reset and advances by one, modulo the line count, after each such replacement. Flush does not move it.
- R9: `flush`=1 invalidates every line at the next edge. While `flush` is 1, `lkp_ready` is 0 and a lookup is not accepted.
- R10: While `miss_req`=1, `lkp_ready` stays 0, `miss_key` stays constant and `rsp_valid` stays 0 until the fill arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Invalidate all lines |
| lkp_valid | input | 1 | Lookup request |
| lkp_key | input | KEY_W | Lookup key |
| lkp_ready | output | 1 | Lookup can be accepted this cycle |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | 1: answered from a line, 0: answered by a fill |
| rsp_result | output | RES_W | Classification decision |
| miss_req | output | 1 | Request pending at the backing classifier |
| miss_key | output | KEY_W | Key of the pending request |
| fill_valid | input | 1 | Fill returned from the classifier |
| fill_lo | input | KEY_W | Lower bound of the returned interval |
| fill_hi | input | KEY_W | Upper bound of the returned interval |
| fill_result | input | RES_W | Decision for the interval and the pending key |

## Verification
The hardest state to reach is a full cache whose rotating pointer has moved, because only misses move it and a miss cannot be forced inside a covered interval. The stimulus first installs disjoint intervals until every line is valid. It then issues misses on uncovered keys and on keys whose lines should just have been evicted, so each eviction shows up as a new miss at a known key. Overlap priority is reached by returning fill intervals that do not contain the missed key. A long sweep over a small key space, with interval widths taken from a shift register, then mixes hits, evictions and periodic flushes against a model in the bench.

// File: rtl/range_cache_pkg.sv
package range_cache_pkg;

  typedef enum logic {
    ST_LOOK = 1'b0,
    ST_WAIT = 1'b1
  } rc_state_e;

  function automatic int unsigned rc_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rc_prio_enc.sv
module rc_prio_enc #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [N-1:0] first_oh
);

  logic seen;

  always_comb begin
    seen     = 1'b0;
    first_oh = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !seen) begin
        first_oh[i] = 1'b1;
        seen        = 1'b1;
      end
    end
    any = seen;
  end

endmodule

// File: rtl/rc_match_array.sv
module rc_match_array #(
  parameter int N     = 8,
  parameter int KEY_W = 32
) (
  input  logic [KEY_W-1:0] key,
  input  logic [N-1:0]     valid,
  input  logic [KEY_W-1:0] lo [N],
  input  logic [KEY_W-1:0] hi [N],
  output logic             hit,
  output logic [N-1:0]     hit_oh
);

  logic [N-1:0] in_range;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign in_range[g] = valid[g] && (key >= lo[g]) && (key <= hi[g]);
  end

  rc_prio_enc #(.N(N)) u_prio (
    .req      (in_range),
    .any      (hit),
    .first_oh (hit_oh)
  );

endmodule

// File: rtl/rc_entry_bank.sv
module rc_entry_bank #(
  parameter int N     = 8,
  parameter int KEY_W = 32,
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [N-1:0]     we,
  input  logic [KEY_W-1:0] wr_lo,
  input  logic [KEY_W-1:0] wr_hi,
  input  logic [RES_W-1:0] wr_res,
  output logic [N-1:0]     valid_q,
  output logic [KEY_W-1:0] lo_q  [N],
  output logic [KEY_W-1:0] hi_q  [N],
  output logic [RES_W-1:0] res_q [N]
);

  logic [N-1:0] valid_d;

  always_comb begin
    if (clr) valid_d = '0;
    else     valid_d = valid_q | we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (we[g]) begin
        lo_q[g]  <= wr_lo;
        hi_q[g]  <= wr_hi;
        res_q[g] <= wr_res;
      end
    end
  end

endmodule

// File: rtl/rc_victim_sel.sv
module rc_victim_sel #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  valid,
  input  logic [IW-1:0] ptr,
  output logic          full,
  output logic [N-1:0]  victim_oh
);

  logic         has_free;
  logic [N-1:0] free_oh;

  rc_prio_enc #(.N(N)) u_free (
    .req      (~valid),
    .any      (has_free),
    .first_oh (free_oh)
  );

  assign full      = !has_free;
  assign victim_oh = has_free ? free_oh : (N'(1) << ptr);

endmodule

// File: rtl/range_cache.sv
module range_cache
  import range_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = 32,
  parameter int RES_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lkp_valid,
  input  logic [KEY_W-1:0] lkp_key,
  output logic             lkp_ready,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [RES_W-1:0] rsp_result,
  output logic             miss_req,
  output logic [KEY_W-1:0] miss_key,
  input  logic             fill_valid,
  input  logic [KEY_W-1:0] fill_lo,
  input  logic [KEY_W-1:0] fill_hi,
  input  logic [RES_W-1:0] fill_result
);

  localparam int IW = rc_idx_w(ENTRIES);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // state
  rc_state_e        state_q, state_d;
  logic [IW-1:0]    ptr_q, ptr_d;
  logic             rsp_valid_q, rsp_valid_d;
  logic             rsp_hit_q, rsp_hit_d;
  logic [RES_W-1:0] rsp_result_q, rsp_result_d;
  logic [KEY_W-1:0] miss_key_q;

  // line storage
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] we_vec;
  logic [KEY_W-1:0]   lo_q  [ENTRIES];
  logic [KEY_W-1:0]   hi_q  [ENTRIES];
  logic [RES_W-1:0]   res_q [ENTRIES];

  logic               hit;
  logic [ENTRIES-1:0] hit_oh;
  logic               full;
  logic [ENTRIES-1:0] victim_oh;
  logic [RES_W-1:0]   hit_res;
  logic               accept;
  logic               fill_take;
  logic               install;

  rc_match_array #(.N(ENTRIES), .KEY_W(KEY_W)) u_match (
    .key    (lkp_key),
    .valid  (valid_q),
    .lo     (lo_q),
    .hi     (hi_q),
    .hit    (hit),
    .hit_oh (hit_oh)
  );

  rc_victim_sel #(.N(ENTRIES), .IW(IW)) u_victim (
    .valid     (valid_q),
    .ptr       (ptr_q),
    .full      (full),
    .victim_oh (victim_oh)
  );

  rc_entry_bank #(.N(ENTRIES), .KEY_W(KEY_W), .RES_W(RES_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .clr     (flush),
    .we      (we_vec),
    .wr_lo   (fill_lo),
    .wr_hi   (fill_hi),
    .wr_res  (fill_result),
    .valid_q (valid_q),
    .lo_q    (lo_q),
    .hi_q    (hi_q),
    .res_q   (res_q)
  );

  // and-or select of the winning line's decision
  always_comb begin
    hit_res = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_res = hit_res | (res_q[i] & {RES_W{hit_oh[i]}});
    end
  end

  assign lkp_ready = (state_q == ST_LOOK) && !flush;
  assign accept    = lkp_valid && lkp_ready;
  assign fill_take = (state_q == ST_WAIT) && fill_valid;
  assign install   = fill_take && !flush;
  assign we_vec    = install ? victim_oh : '0;

  // next state
  always_comb begin
    state_d = state_q;
    if (accept && !hit)  state_d = ST_WAIT;
    else if (fill_take)  state_d = ST_LOOK;

    ptr_d = ptr_q;
    if (install && full) begin
      if (ptr_q == IW'(ENTRIES - 1)) ptr_d = '0;
      else                           ptr_d = ptr_q + 1'b1;
    end

    rsp_valid_d  = (accept && hit) || fill_take;
    rsp_hit_d    = accept && hit;
    rsp_result_d = fill_take ? fill_result : hit_res;
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q     <= ST_LOOK;
      ptr_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      ptr_q       <= ptr_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_hit_q   <= rsp_hit_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_valid_d) rsp_result_q <= rsp_result_d;
  end

  always_ff @(posedge clk) begin
    if (accept) miss_key_q <= lkp_key;
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_hit    = rsp_hit_q;
  assign rsp_result = rsp_result_q;
  assign miss_req   = (state_q == ST_WAIT);
  assign miss_key   = miss_key_q;

endmodule

// File: rtl/range_cache_chk.sv
module range_cache_chk #(
  parameter int N     = 8,
  parameter int KEY_W = 32,
  parameter int RES_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             lkp_valid,
  input logic             lkp_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [RES_W-1:0] rsp_result,
  input logic             miss_req,
  input logic [KEY_W-1:0] miss_key,
  input logic             fill_valid,
  input logic [RES_W-1:0] fill_result,
  input logic [N-1:0]     valid_q,
  input logic [N-1:0]     we_vec
);

  // R2 R3
  lookup_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && lkp_ready) |=>
      ((rsp_valid && rsp_hit && !miss_req) || (miss_req && !rsp_valid)));

  // R3
  miss_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req |-> !lkp_ready);

  // R4
  fill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_req && fill_valid) |=>
      (rsp_valid && !rsp_hit && !miss_req && rsp_result == $past(fill_result)));

  // R5
  idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss_req && fill_valid && !flush) |=> ($stable(valid_q) && !rsp_valid));

  // R7
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_vec));

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

  // R10
  miss_key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_req && !fill_valid) |=> (miss_req && $stable(miss_key) && !rsp_valid));

endmodule

bind range_cache range_cache_chk #(
  .N     (ENTRIES),
  .KEY_W (KEY_W),
  .RES_W (RES_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .flush       (flush),
  .lkp_valid   (lkp_valid),
  .lkp_ready   (lkp_ready),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_result  (rsp_result),
  .miss_req    (miss_req),
  .miss_key    (miss_key),
  .fill_valid  (fill_valid),
  .fill_result (fill_result),
  .valid_q     (valid_q),
  .we_vec      (we_vec)
);

// File: tb/range_cache_tb.sv
`timescale 1ns/1ps
module range_cache_tb;

  localparam int N  = 8;
  localparam int KW = 32;
  localparam int RW = 8;

  logic          clk, rst_n, flush, lkp_valid, fill_valid;
  logic [KW-1:0] lkp_key, fill_lo, fill_hi;
  logic [RW-1:0] fill_result;
  logic          lkp_ready, rsp_valid, rsp_hit, miss_req;
  logic [RW-1:0] rsp_result;
  logic [KW-1:0] miss_key;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [KW-1:0] m_lo  [N];
  logic [KW-1:0] m_hi  [N];
  logic [RW-1:0] m_res [N];
  bit            m_val [N];
  int            m_ptr;

  range_cache #(.ENTRIES(N), .KEY_W(KW), .RES_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lkp_valid(lkp_valid), .lkp_key(lkp_key), .lkp_ready(lkp_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_result(rsp_result),
    .miss_req(miss_req), .miss_key(miss_key),
    .fill_valid(fill_valid), .fill_lo(fill_lo), .fill_hi(fill_hi),
    .fill_result(fill_result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int model_find(input logic [KW-1:0] k);
    for (int i = 0; i < N; i++)
      if (m_val[i] && k >= m_lo[i] && k <= m_hi[i]) return i;
    return -1;
  endfunction

  task automatic model_install(input logic [KW-1:0] lo, input logic [KW-1:0] hi,
                               input logic [RW-1:0] res);
    int slot = -1;
    for (int i = 0; i < N; i++)
      if (!m_val[i] && slot < 0) slot = i;
    if (slot < 0) begin
      slot  = m_ptr;
      m_ptr = (m_ptr + 1) % N;
    end
    m_val[slot] = 1'b1;
    m_lo[slot]  = lo;
    m_hi[slot]  = hi;
    m_res[slot] = res;
  endtask

  task automatic model_flush();
    for (int i = 0; i < N; i++) m_val[i] = 1'b0;
  endtask

  // called at a falling edge, returns at a falling edge
  task automatic lookup(input logic [KW-1:0] key, input logic [KW-1:0] flo,
                        input logic [KW-1:0] fhi, input logic [RW-1:0] fres,
                        input string tag);
    int e = model_find(key);
    lkp_valid = 1'b1;
    lkp_key   = key;
    @(posedge clk);
    @(negedge clk);
    lkp_valid = 1'b0;
    if (e >= 0) begin
      chk(rsp_valid && rsp_hit && !miss_req, tag, "hit flags",
          {rsp_valid, rsp_hit, miss_req}, 3'b110);
      chk(rsp_result == m_res[e], tag, "hit result", rsp_result, m_res[e]);
    end else begin
      chk(!rsp_valid && miss_req && !lkp_ready, tag, "miss flags",
          {rsp_valid, miss_req, lkp_ready}, 3'b010);
      chk(miss_key == key, tag, "miss key", miss_key, key);
      repeat (2) begin
        @(negedge clk);
        chk(!lkp_ready && miss_req && !rsp_valid && miss_key == key, "R10",
            "wait hold", {lkp_ready, miss_req, rsp_valid}, 3'b010);
      end
      fill_valid  = 1'b1;
      fill_lo     = flo;
      fill_hi     = fhi;
      fill_result = fres;
      @(posedge clk);
      @(negedge clk);
      fill_valid = 1'b0;
      chk(rsp_valid && !rsp_hit && !miss_req && lkp_ready, tag, "fill resp flags",
          {rsp_valid, rsp_hit, miss_req, lkp_ready}, 4'b1001);
      chk(rsp_result == fres, tag, "fill result", rsp_result, fres);
      model_install(flo, fhi, fres);
    end
  endtask

  task automatic do_flush(input logic [KW-1:0] key);
    flush     = 1'b1;
    lkp_valid = 1'b1;
    lkp_key   = key;
    #1;
    chk(!lkp_ready, "R9", "ready during flush", lkp_ready, 0);
    @(posedge clk);
    @(negedge clk);
    flush     = 1'b0;
    lkp_valid = 1'b0;
    chk(!rsp_valid && !miss_req, "R9", "lookup ignored in flush",
        {rsp_valid, miss_req}, 2'b00);
    model_flush();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; flush = 1'b0; lkp_valid = 1'b0; fill_valid = 1'b0;
    lkp_key = '0; fill_lo = '0; fill_hi = '0; fill_result = '0;
    m_ptr = 0;
    model_flush();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(lkp_ready && !rsp_valid && !miss_req, "R1", "reset outputs",
        {lkp_ready, rsp_valid, miss_req}, 3'b100);
    lookup(32'h1234, 32'h1000, 32'h1FFF, 8'h11, "R1");

    // R2 inclusive bounds, R3/R4 misses just outside
    lookup(32'h1000, 0, 0, 0, "R2");
    lookup(32'h1FFF, 0, 0, 0, "R2");
    lookup(32'h0FFF, 32'h0F00, 32'h0FFF, 8'h22, "R3");
    lookup(32'h2000, 32'h2000, 32'h20FF, 8'h33, "R4");
    lookup(32'h0F00, 0, 0, 0, "R4");
    lookup(32'h20FF, 0, 0, 0, "R4");

    // R5 fill with no pending miss
    fill_valid = 1'b1; fill_lo = 32'h9000; fill_hi = 32'h9010; fill_result = 8'h99;
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0;
    chk(!rsp_valid && lkp_ready, "R5", "no response to idle fill",
        {rsp_valid, lkp_ready}, 2'b01);
    lookup(32'h9005, 32'h9005, 32'h9005, 8'h98, "R5");

    // R9 flush
    do_flush(32'h1234);
    lookup(32'h1234, 32'h1200, 32'h12FF, 8'h44, "R9");

    // R6 overlap: older wide line in entry 0 wins
    do_flush(0);
    lookup(32'h50000, 32'h0, 32'hFFFF, 8'hA1, "R6");
    lookup(32'h60000, 32'h100, 32'h10F, 8'hB2, "R6");
    lookup(32'h105, 0, 0, 0, "R6");
    chk(rsp_result == 8'hA1, "R6", "lowest index wide", rsp_result, 8'hA1);
    // R6 overlap: narrow line in entry 0 wins
    do_flush(0);
    lookup(32'h50000, 32'h100, 32'h10F, 8'hB2, "R6");
    lookup(32'h60000, 32'h0, 32'hFFFF, 8'hA1, "R6");
    lookup(32'h105, 0, 0, 0, "R6");
    chk(rsp_result == 8'hB2, "R6", "lowest index narrow", rsp_result, 8'hB2);

    // R7 free lines used before any eviction
    do_flush(0);
    for (int i = 0; i < 3; i++)
      lookup(32'h7000 + i * 16, 32'h7000 + i * 16, 32'h700F + i * 16, 8'h70 + 8'(i), "R7");
    for (int i = 0; i < 3; i++)
      lookup(32'h7008 + i * 16, 0, 0, 0, "R7");

    // R8 rotating replacement (pointer advanced once by the R6/R7 phases? no: never full)
    do_flush(0);
    for (int i = 0; i < N; i++)
      lookup(i * 32'h100, i * 32'h100, i * 32'h100 + 32'hF, 8'(i), "R8");
    lookup(32'h5000, 32'h5000, 32'h500F, 8'hC0, "R8");
    lookup(32'h0, 32'h0, 32'hF, 8'hC1, "R8");
    lookup(32'h100, 32'h100, 32'h10F, 8'hC2, "R8");
    lookup(32'h300, 0, 0, 0, "R8");
    lookup(32'h5004, 0, 0, 0, "R8");

    // sweep over a small key space
    lfsr = 16'hACE1;
    for (int it = 0; it < 400; it++) begin
      logic [KW-1:0] k, w, lo;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      k  = KW'(lfsr[7:0]);
      w  = KW'(2) << lfsr[9:8];
      lo = k & ~(w - 1);
      if (it % 60 == 59) do_flush(k);
      else lookup(k, lo, lo + w - 1, 8'(k) ^ 8'h5A, "R2/R4");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule